// File: doc/BRIEF.md
# Address-Latched Bank Register File

This block holds the bank-select registers of a cartridge-side memory controller on a 6502-class CPU bus. A store to the controller's window does not carry the bank number on the data lines: the number comes from the low address lines of the store itself. The address bits just below the top one choose which register is loaded. A single store instruction can therefore switch a bank in one bus cycle and leave every CPU register untouched. An indexed store lets the bank number come from an index register.

The block watches the CPU address bus, the read/write line and the M2 phase clock, all sampled by a faster system clock. A store is recognised when R/W is low, A15 is high and M2 is high. The address seen in the last system-clock sample with M2 high is committed when M2 is first sampled low. The block has no data-bus input, so the data the CPU drives cannot reach a register. The width of each register is a parameter, and a wider register uses more of the low address lines.

Top module: `abr_bank_file`

## Requirements
- R1: While `rst_n` is low, and after it is released, every bank register reads 0 until a store is committed.
- R2: A store cycle loads the register selected by A14..A12 with the value on address bits A[VAL_W-1:0]. It needs R/W low and A15 high while M2 is sampled high. The new value appears at `bank_flat[sel*VAL_W +: VAL_W]` on the system-clock edge where M2 is first sampled low after being high.
- R3: A store changes only the register its A14..A12 field selects. All other registers keep their values.
- R4: A bus cycle with R/W high (a read) changes no register, even at addresses in the register window.
- R5: A bus cycle with A15 low changes no register, whatever R/W and the other address bits are.
- R6: The committed value and selection come from the address present while M2 was high. An address that changes at the same moment M2 falls has no effect.
- R7: When no store is committed, every register holds its value on every system clock.
- R8: With VAL_W = 12, a store loads all of A11..A0. With the default VAL_W = 8, bits A11..A8 are ignored and only A7..A0 are stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the CPU bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus A15..A0 |
| cpu_rw | input | 1 | CPU read/write line, low for a write |
| cpu_m2 | input | 1 | CPU M2 phase clock, high while the bus is valid |
| bank_flat | output | NUM_REGS*VAL_W (64) | All bank registers, register k at bits [k*VAL_W +: VAL_W] |

## Verification
The whole register state is visible on `bank_flat`, so a wrong internal state shows at the ports on the first system-clock edge after the faulty commit. A store with the wrong select field shows as a changed register that should have held and a register that missed its value. A stale or late captured address shows as a value that matches the address after the M2 fall rather than the one before it. A bad R/W or A15 qualification shows as a change after a read or a low-half access.

// File: rtl/abr_pkg.sv
package abr_pkg;
  localparam int CPU_AW   = 16;
  localparam int SEL_W    = 3;
  localparam int SEL_LSB  = CPU_AW - 1 - SEL_W;
  localparam int NUM_REGS = 1 << SEL_W;

  // A bus cycle is a store into the register window.
  function automatic logic f_is_store(input logic rw, input logic a15);
    return (!rw) && a15;
  endfunction

  // One-hot slot vector for a select field, gated by the commit pulse.
  function automatic logic [NUM_REGS-1:0] f_slot(input logic fire,
                                                 input logic [SEL_W-1:0] sel);
    logic [NUM_REGS-1:0] v;
    v = '0;
    if (fire) v[sel] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/abr_bus_qualifier.sv
module abr_bus_qualifier
  import abr_pkg::*;
#(
  parameter int VAL_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CPU_AW-1:0]   cpu_addr,
  input  logic                cpu_rw,
  input  logic                cpu_m2,
  output logic                wr_fire,
  output logic [SEL_W-1:0]    wr_sel,
  output logic [VAL_W-1:0]    wr_val
);
  logic             m2_q;
  logic             store_q;
  logic [SEL_W-1:0] sel_q;
  logic [VAL_W-1:0] val_q;
  logic             m2_fall;
  logic             addr_spare_unused;

  assign addr_spare_unused = ^cpu_addr;

  // Capture the bus on every sample taken while M2 is high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m2_q    <= 1'b0;
      store_q <= 1'b0;
      sel_q   <= '0;
      val_q   <= '0;
    end else begin
      m2_q <= cpu_m2;
      if (cpu_m2) begin
        store_q <= f_is_store(cpu_rw, cpu_addr[CPU_AW-1]);
        sel_q   <= cpu_addr[CPU_AW-2 -: SEL_W];
        val_q   <= cpu_addr[VAL_W-1:0];
      end
    end
  end

  assign m2_fall = m2_q && !cpu_m2;
  assign wr_fire = m2_fall && store_q;
  assign wr_sel  = sel_q;
  assign wr_val  = val_q;

  // R2: a commit only follows a sample with M2 high.
  assert_fire_after_m2_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> $past(cpu_m2));
  // R2: one commit per M2 fall.
  assert_fire_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !wr_fire);
endmodule

// File: rtl/abr_sel_decode.sv
module abr_sel_decode
  import abr_pkg::*;
(
  input  logic                wr_fire,
  input  logic [SEL_W-1:0]    wr_sel,
  output logic [NUM_REGS-1:0] slot_load
);
  always_comb slot_load = f_slot(wr_fire, wr_sel);

  // R3: never more than one register loaded by a commit.
  always_comb begin
    assert_one_slot_R3: assert ($onehot0(slot_load));
  end
endmodule

// File: rtl/abr_bank_reg.sv
module abr_bank_reg #(
  parameter int VAL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [VAL_W-1:0] val,
  output logic [VAL_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= val;
  end

  // R7: no load, no change.
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
  // R2: a load takes the offered value.
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(val)));
endmodule

// File: rtl/abr_bank_file.sv
module abr_bank_file
  import abr_pkg::*;
#(
  parameter int VAL_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [15:0]               cpu_addr,
  input  logic                      cpu_rw,
  input  logic                      cpu_m2,
  output logic [NUM_REGS*VAL_W-1:0] bank_flat
);
  logic                wr_fire;
  logic [SEL_W-1:0]    wr_sel;
  logic [VAL_W-1:0]    wr_val;
  logic [NUM_REGS-1:0] slot_load;

  abr_bus_qualifier #(.VAL_W(VAL_W)) qual_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
    .cpu_m2(cpu_m2), .wr_fire(wr_fire), .wr_sel(wr_sel), .wr_val(wr_val)
  );

  abr_sel_decode dec_i (
    .wr_fire(wr_fire), .wr_sel(wr_sel), .slot_load(slot_load)
  );

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_bank
    abr_bank_reg #(.VAL_W(VAL_W)) reg_i (
      .clk(clk), .rst_n(rst_n), .load(slot_load[k]), .val(wr_val),
      .q(bank_flat[k*VAL_W +: VAL_W])
    );
  end

  // R4/R5: with no M2 fall, the whole file is stable.
  assert_quiet_without_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_load) |=> $stable(bank_flat));
endmodule

// File: tb/abr_bank_file_tb_top.sv
`timescale 1ns/1ps
module abr_bank_file_tb_top;
  localparam int NR = 8;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rw = 1'b1;
  logic        cpu_m2 = 1'b0;
  logic [NR*8-1:0]  bank8;
  logic [NR*12-1:0] bank12;

  int checks = 0;
  int errors = 0;
  logic [7:0]  exp8  [NR];
  logic [11:0] exp12 [NR];

  always #2.5 clk = ~clk;

  abr_bank_file #(.VAL_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
    .cpu_m2(cpu_m2), .bank_flat(bank8));

  abr_bank_file #(.VAL_W(12)) dut_w_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
    .cpu_m2(cpu_m2), .bank_flat(bank12));

  task automatic clear_model();
    for (int k = 0; k < NR; k++) begin exp8[k] = '0; exp12[k] = '0; end
  endtask

  task automatic check_all(input string tag);
    for (int k = 0; k < NR; k++) begin
      checks++;
      if (bank8[k*8 +: 8] !== exp8[k]) begin
        errors++;
        $display("FAIL %s reg%0d width8 actual %h expected %h", tag, k, bank8[k*8 +: 8], exp8[k]);
      end
      checks++;
      if (bank12[k*12 +: 12] !== exp12[k]) begin
        errors++;
        $display("FAIL %s reg%0d width12 actual %h expected %h", tag, k, bank12[k*12 +: 12], exp12[k]);
      end
    end
  endtask

  // One bus cycle: address during M2 high is 'a'; 'a_fall' appears as M2 falls.
  task automatic bus_cycle(input logic [15:0] a, input logic rw, input logic [15:0] a_fall);
    @(negedge clk); cpu_addr = a; cpu_rw = rw; cpu_m2 = 1'b0;
    @(negedge clk); cpu_m2 = 1'b1;
    repeat (3) @(negedge clk);
    cpu_m2 = 1'b0; cpu_addr = a_fall;
    if (!rw && a[15]) begin
      exp8[a[14:12]]  = a[7:0];
      exp12[a[14:12]] = a[11:0];
    end
    repeat (2) @(negedge clk);
    cpu_rw = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; clear_model();
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R1 after release");
  endtask

  task automatic t_store_abs();
    for (int k = 0; k < NR; k++) begin
      logic [15:0] a;
      a = 16'h8000 | 16'(k << 12) | 16'(8'h11 * (k + 1));
      bus_cycle(a, 1'b0, a);
      check_all("R2 R3 store absolute");
    end
  endtask

  task automatic t_store_indexed();
    for (int x = 0; x < 256; x += 51) begin
      logic [15:0] a;
      a = 16'hC000 + 16'(x);
      bus_cycle(a, 1'b0, a);
      check_all("R2 R3 store indexed");
    end
  endtask

  task automatic t_read();
    bus_cycle(16'hB0AA, 1'b1, 16'hB0AA);
    check_all("R4 read in window");
  endtask

  task automatic t_low_half();
    bus_cycle(16'h7055, 1'b0, 16'h7055);
    check_all("R5 A15 low store");
    bus_cycle(16'h1233, 1'b0, 16'h1233);
    check_all("R5 A15 low store 2");
  endtask

  task automatic t_late_addr();
    bus_cycle(16'hE03C, 1'b0, 16'h9FFF);
    check_all("R6 address after M2 fall");
  endtask

  task automatic t_hold();
    cpu_addr = 16'hFFFF; cpu_rw = 1'b0;
    repeat (20) @(negedge clk);
    cpu_rw = 1'b1;
    check_all("R7 idle hold");
  endtask

  task automatic t_wide();
    bus_cycle(16'hDA5C, 1'b0, 16'hDA5C);
    check_all("R8 wide value A11..A0");
    bus_cycle(16'h8F00, 1'b0, 16'h8F00);
    check_all("R8 upper bits ignored at width 8");
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_model();
    t_reset();
    t_store_abs();
    t_store_indexed();
    t_read();
    t_low_half();
    t_late_addr();
    t_hold();
    t_wide();
    t_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule